// File: doc/BRIEF.md
# 64-bit Compare-Match Event Timer

This peripheral holds a free-running 64-bit up-counter that advances by one every clock while counting is enabled, and a 64-bit compare value. When the compare path is armed and the counter has reached or passed the compare value, the block raises a sticky event flag. If interrupts are enabled, the flag also drives a level interrupt. An optional stepping mode adds a programmable 32-bit interval to the compare value on every event, so software gets a steady stream of periodic events without rewriting the compare value.

Software reaches the block through a single-cycle 32-bit register port. A write takes effect on the clock edge where `we` is high. Read data is combinational from `addr`. Each 32-bit half of the counter is read live, with no snapshot. Software that needs a consistent 64-bit value reads high, low, high and retries if the two high reads differ.

The compare path is a three-state arming machine:
- **OFF** (compare disabled). Moves to **ARMED** once the compare enable is set.
- **ARMED**. On an event with stepping off, it moves to **SPENT**. On an event with stepping on, it stays in **ARMED**.
- **SPENT**. Produces no further events. It returns to **ARMED** when either half of the compare value is written.
- Clearing the compare enable sends any state back to **OFF**.

Events are produced in **OFF** and **ARMED**, but only while the enable is set. This is why a match that is already true on the cycle the enable is set fires at once.

Register offsets (byte addresses):
- 0x00: counter low
- 0x04: counter high
- 0x08: control
- 0x0C: status
- 0x10: compare low
- 0x14: compare high
- 0x18: step

Top module: `cmp_timer64`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While control bit 0 is set, the counter advances by exactly one per clock. While it is clear, the counter holds.
- R3: A write to 0x00 or 0x04 loads that counter half. Control at 0x08 keeps bits 3:0 (bit 0 count, bit 1 compare enable, bit 2 interrupt enable, bit 3 stepping), and its upper bits read zero.
- R4: The counter halves are read live and independently, so a carry between a low read and a later high read is visible to software.
- R5: With compare enabled, an event occurs whenever the counter is greater than or equal to the compare value (0x10 low, 0x14 high). The flag (status 0x0C bit 0) reads one on the clock after the first such cycle.
- R6: With compare disabled, no event occurs. Re-enabling with the match already true sets the flag one clock after the enabling write.
- R7: With stepping off, one compare value yields one event. After that event and a flag clear, the flag stays clear until a compare half is rewritten, which re-arms the match.
- R8: With stepping on, each event adds the step register (0x18) to the compare value, visible at 0x10/0x14 one clock after the event.
- R9: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it set. An event in the same cycle as a clear leaves the flag set.
- R10: `irq` is high exactly when the flag is set and control bit 2 is set. The flag stays set while bit 2 is clear.
- R11: Offsets outside the seven registers read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte offset of the register |
| we | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt: flag and interrupt enable |

## Verification
The bench times the first event to the exact clock. This separates a greater-or-equal comparator from an equality one, and it exposes a missing or extra register stage on the flag. After the flag is cleared while the counter sits past the compare value, the bench checks that the flag stays clear. A design without the spent state would refire on every cycle. The bench reads the low half just before a carry and the high half just after it, which exposes any hidden snapshot. It also lands a flag clear on the same edge as a stepping event, so a design where the clear wins would lose that periodic event.

// File: rtl/cmp_timer64_pkg.sv
package cmp_timer64_pkg;

    // Byte offsets of the register window
    localparam int unsigned OFF_CNT_LO = 32'h00;
    localparam int unsigned OFF_CNT_HI = 32'h04;
    localparam int unsigned OFF_CTRL   = 32'h08;
    localparam int unsigned OFF_STAT   = 32'h0C;
    localparam int unsigned OFF_CMP_LO = 32'h10;
    localparam int unsigned OFF_CMP_HI = 32'h14;
    localparam int unsigned OFF_STEP   = 32'h18;

    localparam int CTRL_W = 4;

    typedef enum logic [1:0] {
        ARM_OFF   = 2'd0,
        ARM_READY = 2'd1,
        ARM_SPENT = 2'd2
    } arm_state_e;

    // Packed from MSB: bit3 stepping, bit2 irq enable, bit1 compare enable, bit0 count
    typedef struct packed {
        logic step_en;
        logic irq_en;
        logic cmp_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/cmp_timer64_counter.sv
module cmp_timer64_counter #(
    parameter  int HALF_W = 32,
    localparam int CNT_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [1:0]        wr_half,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // A direct write to a half overrides that half of the incremented value
    always_comb begin
        cnt_d = run ? cnt_q + CNT_W'(1) : cnt_q;
        for (int h = 0; h < 2; h++) begin
            if (wr_half[h]) begin
                cnt_d[h*HALF_W +: HALF_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/cmp_timer64_cmpreg.sv
module cmp_timer64_cmpreg #(
    parameter  int HALF_W = 32,
    localparam int CNT_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wr_half,
    input  logic              wr_step,
    input  logic              add_step,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [HALF_W-1:0] step_o
);

    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  cmp_d;
    logic [HALF_W-1:0] step_q;

    // Software writes win over the stepping add on the half they touch
    always_comb begin
        cmp_d = add_step ? cmp_q + {{HALF_W{1'b0}}, step_q} : cmp_q;
        for (int h = 0; h < 2; h++) begin
            if (wr_half[h]) begin
                cmp_d[h*HALF_W +: HALF_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            step_q <= '0;
        end else begin
            cmp_q <= cmp_d;
            if (wr_step) begin
                step_q <= wdata;
            end
        end
    end

    assign cmp_o  = cmp_q;
    assign step_o = step_q;

endmodule

// File: rtl/cmp_timer64_arm.sv
module cmp_timer64_arm
    import cmp_timer64_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_en,
    input  logic step_en,
    input  logic match,
    input  logic cmp_wr,
    output logic fire_o
);

    arm_state_e state_q;
    arm_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: an event in OFF or READY whenever enabled and matched
    always_comb begin
        fire_o = 1'b0;
        unique case (state_q)
            ARM_OFF:   fire_o = cmp_en && match;
            ARM_READY: fire_o = cmp_en && match;
            ARM_SPENT: fire_o = 1'b0;
            default:   fire_o = 1'b0;
        endcase
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (!cmp_en) begin
            state_d = ARM_OFF;
        end else begin
            unique case (state_q)
                ARM_OFF, ARM_READY: begin
                    state_d = (fire_o && !step_en && !cmp_wr) ? ARM_SPENT : ARM_READY;
                end
                ARM_SPENT: begin
                    state_d = cmp_wr ? ARM_READY : ARM_SPENT;
                end
                default: state_d = ARM_OFF;
            endcase
        end
    end

endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
    import cmp_timer64_pkg::*;
#(
    parameter  int BUS_W  = 32,
    parameter  int ADDR_W = 5,
    localparam int CNT_W  = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO);
    localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFF_CMP_LO);
    localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFF_CMP_HI);
    localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(OFF_STEP);

    ctrl_t              ctrl_q;
    logic               flag_q;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cmp;
    logic [BUS_W-1:0]   step;
    logic [1:0]         wr_cnt_half;
    logic [1:0]         wr_cmp_half;
    logic               wr_ctrl;
    logic               wr_step;
    logic               clr_flag;
    logic               match;
    logic               fire;

    // Write decode
    assign wr_cnt_half[0] = we && (addr == A_CNT_LO);
    assign wr_cnt_half[1] = we && (addr == A_CNT_HI);
    assign wr_cmp_half[0] = we && (addr == A_CMP_LO);
    assign wr_cmp_half[1] = we && (addr == A_CMP_HI);
    assign wr_ctrl        = we && (addr == A_CTRL);
    assign wr_step        = we && (addr == A_STEP);
    assign clr_flag       = we && (addr == A_STAT) && wdata[0];

    cmp_timer64_counter #(.HALF_W(BUS_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .wr_half (wr_cnt_half),
        .wdata   (wdata),
        .cnt_o   (cnt)
    );

    cmp_timer64_cmpreg #(.HALF_W(BUS_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_half  (wr_cmp_half),
        .wr_step  (wr_step),
        .add_step (fire && ctrl_q.step_en),
        .wdata    (wdata),
        .cmp_o    (cmp),
        .step_o   (step)
    );

    assign match = (cnt >= cmp);

    cmp_timer64_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_en  (ctrl_q.cmp_en),
        .step_en (ctrl_q.step_en),
        .match   (match),
        .cmp_wr  (|wr_cmp_half),
        .fire_o  (fire)
    );

    // Control and sticky flag; a new event outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            end
            if (fire) begin
                flag_q <= 1'b1;
            end else if (clr_flag) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign irq = flag_q && ctrl_q.irq_en;

    // Live read mux: counter halves are never latched
    always_comb begin
        case (addr)
            A_CNT_LO: rdata = cnt[BUS_W-1:0];
            A_CNT_HI: rdata = cnt[CNT_W-1:BUS_W];
            A_CTRL:   rdata = BUS_W'(ctrl_q);
            A_STAT:   rdata = BUS_W'(flag_q);
            A_CMP_LO: rdata = cmp[BUS_W-1:0];
            A_CMP_HI: rdata = cmp[CNT_W-1:BUS_W];
            A_STEP:   rdata = step;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmp_timer64_chk.sv
module cmp_timer64_chk
    import cmp_timer64_pkg::*;
#(
    parameter  int BUS_W  = 32,
    parameter  int ADDR_W = 5,
    localparam int CNT_W  = 2 * BUS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic              wbit0,
    input logic              irq,
    input logic [3:0]        ctrl,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [BUS_W-1:0]  step,
    input logic              flag,
    input logic              fire
);

    logic wr_cnt;
    logic wr_cmp;
    logic wr_clr;

    assign wr_cnt = we && ((addr == ADDR_W'(OFF_CNT_LO)) || (addr == ADDR_W'(OFF_CNT_HI)));
    assign wr_cmp = we && ((addr == ADDR_W'(OFF_CMP_LO)) || (addr == ADDR_W'(OFF_CMP_HI)));
    assign wr_clr = we && (addr == ADDR_W'(OFF_STAT)) && wbit0;

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && !wr_cnt) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[0] && !wr_cnt) |=> $stable(cnt));

    p_flag_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag);

    p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[1] |-> !fire);

    p_single_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ctrl[3] && !wr_cmp) |=> !fire);

    p_auto_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ctrl[3] && !wr_cmp) |=> (cmp == $past(cmp) + {{BUS_W{1'b0}}, $past(step)}));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_clr) |=> flag);

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[2] |-> !irq);

endmodule

bind cmp_timer64 cmp_timer64_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .addr  (addr),
    .wbit0 (wdata[0]),
    .irq   (irq),
    .ctrl  (ctrl_q),
    .cnt   (cnt),
    .cmp   (cmp),
    .step  (step),
    .flag  (flag_q),
    .fire  (fire)
);

// File: tb/cmp_timer64_tb.sv
module cmp_timer64_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cmp_timer64 u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .we    (we),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    // {write, addr, data-or-expected}; run with counting stopped
    localparam int NV = 18;
    localparam logic [37:0] VEC [NV] = '{
        {1'b1, 5'h00, 32'h12345678},
        {1'b1, 5'h04, 32'h9ABCDEF0},
        {1'b0, 5'h00, 32'h12345678},
        {1'b0, 5'h04, 32'h9ABCDEF0},
        {1'b1, 5'h10, 32'h00000055},
        {1'b1, 5'h14, 32'h00000001},
        {1'b0, 5'h10, 32'h00000055},
        {1'b0, 5'h14, 32'h00000001},
        {1'b1, 5'h18, 32'h00000100},
        {1'b0, 5'h18, 32'h00000100},
        {1'b1, 5'h08, 32'hFFFFFFF0},
        {1'b0, 5'h08, 32'h00000000},
        {1'b1, 5'h08, 32'h00000008},
        {1'b0, 5'h08, 32'h00000008},
        {1'b1, 5'h1C, 32'hDEADBEEF},
        {1'b0, 5'h1C, 32'h00000000},
        {1'b0, 5'h02, 32'h00000000},
        {1'b1, 5'h08, 32'h00000000}
    };

    function automatic string req_of(input logic [4:0] a);
        case (a)
            5'h10, 5'h14, 5'h18: return "R8 cmp/step readback";
            5'h00, 5'h04, 5'h08: return "R3 register readback";
            default:             return "R11 unused offset";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        we = 1'b0; addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rchk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        logic [31:0] v0;
        logic [31:0] v1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 7; a++) rchk(5'(a * 4), 32'h0, "R1 reset register");
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // Table walk: R3, R8, R11 register behaviour
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][37]) wr(VEC[i][36:32], VEC[i][31:0]);
            else rchk(VEC[i][36:32], VEC[i][31:0], req_of(VEC[i][36:32]));
        end

        // R4: carry between two live half reads
        wr(5'h00, 32'hFFFFFFFE);
        wr(5'h04, 32'h0);
        wr(5'h08, 32'h1);
        rchk(5'h00, 32'hFFFFFFFE, "R2 first count cycle");
        @(negedge clk);
        rchk(5'h00, 32'hFFFFFFFF, "R4 low before carry");
        @(negedge clk);
        rchk(5'h04, 32'h1, "R4 high after carry");
        rchk(5'h00, 32'h0, "R4 low after carry");
        wr(5'h08, 32'h0);
        rchk(5'h00, 32'h1, "R2 last step before stop");
        repeat (3) @(negedge clk);
        rchk(5'h00, 32'h1, "R2 hold while stopped");

        // R5/R7: single shot at counter >= compare
        wr(5'h00, 32'h0); wr(5'h04, 32'h0);
        wr(5'h10, 32'd10); wr(5'h14, 32'h0);
        wr(5'h0C, 32'h1);
        wr(5'h08, 32'h7);
        repeat (10) @(negedge clk);
        rchk(5'h0C, 32'h0, "R5 flag before match");
        @(negedge clk);
        rchk(5'h0C, 32'h1, "R5 flag after match");
        chk("R10 irq with flag", {31'b0, irq}, 32'h1);
        rchk(5'h00, 32'd11, "R2 count at event");
        wr(5'h0C, 32'h1);
        rchk(5'h0C, 32'h0, "R9 write-one clear");
        repeat (4) @(negedge clk);
        rchk(5'h0C, 32'h0, "R7 no refire past compare");
        chk("R7 irq stays low", {31'b0, irq}, 32'h0);
        wr(5'h10, 32'h0);
        @(negedge clk);
        rchk(5'h0C, 32'h1, "R7 rewrite re-arms");
        wr(5'h0C, 32'h0);
        rchk(5'h0C, 32'h1, "R9 write zero keeps flag");
        wr(5'h08, 32'h3);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        rchk(5'h0C, 32'h1, "R10 flag kept while masked");
        wr(5'h0C, 32'h1);

        // R6: compare disabled, then re-enabled with match true
        wr(5'h08, 32'h5);
        wr(5'h0C, 32'h1);
        repeat (4) @(negedge clk);
        rchk(5'h0C, 32'h0, "R6 no event while disabled");
        wr(5'h08, 32'h7);
        rchk(5'h0C, 32'h0, "R6 not yet on enable edge");
        @(negedge clk);
        rchk(5'h0C, 32'h1, "R6 event after re-enable");

        // R8: stepping
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h1);
        wr(5'h00, 32'h0); wr(5'h04, 32'h0);
        wr(5'h10, 32'd20); wr(5'h14, 32'h0);
        wr(5'h18, 32'd8);
        wr(5'h08, 32'hF);
        repeat (21) @(negedge clk);
        rchk(5'h10, 32'd28, "R8 first step");
        rchk(5'h0C, 32'h1, "R8 first event flag");
        wr(5'h0C, 32'h1);
        rchk(5'h0C, 32'h0, "R9 clear between periods");
        repeat (6) @(negedge clk);
        rchk(5'h0C, 32'h0, "R8 no event before next period");
        rchk(5'h10, 32'd28, "R8 compare held between periods");
        wr(5'h0C, 32'h1);
        rchk(5'h0C, 32'h1, "R9 event beats clear");
        rchk(5'h10, 32'd36, "R8 second step");
        rchk(5'h14, 32'h0, "R8 compare high");
        rd(5'h1C, v0); rd(5'h00, v1);
        chk("R11 unused read while running", v0, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule